// File: doc/BRIEF.md
# Slot-Pair Valid/Data Extractor

This block sits between the serial output of a signal processor and a time-division-multiplexed byte bus. A small per-slot map gives every time slot a four-bit source code and a bus number. Two consecutive slots bound into a pair take one serial transfer. The first slot is coded 0xC and the second is coded 0xD, and both name the same bus. The pair therefore carries its own per-slot valid flag in-band. This lets the processor mark slots that hold no usable data, for instance after a frame slip on an incoming line.

At the start of the first slot of a pair the block raises a one-cycle request toward the processor. It then shifts in a 16-bit word, most significant bit first. The block keeps only bit 14 of the word as the valid flag and bits 7:0 as the data byte. The captured pair is stored in one of two banks, selected by frame parity. It is driven onto the named bus in the pair's second slot of the following frame, so the latency is always one frame. During the first slot of a pair the block drives its bus with valid low. A 0xC slot that has no matching 0xD after it also drives valid low and sets a sticky error flag.

Top module: `slot_pair_extractor`

## Requirements
- R1: `dsp_req` is high for exactly one cycle, in the cycle after a slot tick, when that slot is coded 0xC and the next slot, inside the same frame, is coded 0xD with the same bus number. It is low in all other cycles.
- R2: After the tick of the first slot of a pair, `out_drive` is 1, `out_bus` is that slot's bus number and `out_valid` is 0 for the whole slot.
- R3: Serial bits are taken on `ser_strobe`, most significant first. After 16 strobes following a request, bit 14 of the word (mask 0x4000) becomes the valid flag and bits 7:0 become the data byte. All other bits are discarded.
- R4: In the second slot of a pair (code 0xD, preceded by a 0xC on the same bus), `out_drive` is 1 and `out_bus` is the slot's bus. `out_valid`/`out_data` are the values captured for that pair in the previous frame. The frame that receives a capture reads the other bank, so a capture never shows in its own frame. A bank entry keeps its value until it is written again.
- R5: A 0xC slot that is not the first slot of a pair drives `out_drive`=1 with `out_valid`=0, raises no request and sets `pair_err`. `pair_err` stays set until reset.
- R6: A slot with any other code, or a 0xD slot without a matching 0xC before it, gives `out_drive`=0, `out_bus`=0, `out_valid`=0 and `out_data`=0.
- R7: Reset clears `dsp_req`, `out_drive`, `out_valid`, `out_data`, `out_bus` and `pair_err`, and it clears both capture banks. A second slot that has had no capture drives valid 0 and data 0.
- R8: A new request abandons any partly received word. The next 16 strobes form the word for the new pair, and the abandoned pair's bank entry is left unchanged.
- R9: Slot ticks are ignored until the first tick that comes with `frame_sync`. That tick starts slot 0, and each later tick without `frame_sync` advances one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Marks the slot tick that starts slot 0 |
| slot_tick | input | 1 | One-cycle pulse at the start of each slot |
| map_we | input | 1 | Slot map write enable |
| map_addr | input | SLOT_W (3) | Slot map entry to write |
| map_code | input | 4 | Source code for the entry (0xC pair head, 0xD pair tail) |
| map_bus | input | BUS_W (2) | Bus number for the entry |
| ser_strobe | input | 1 | Serial bit is present on `ser_bit` |
| ser_bit | input | 1 | Serial data bit, most significant first |
| dsp_req | output | 1 | One-cycle request for a pair's serial word |
| out_drive | output | 1 | Block owns the bus in this slot |
| out_bus | output | BUS_W (2) | Bus being driven |
| out_valid | output | 1 | Per-slot valid for the driven bus |
| out_data | output | 8 | Data byte for the driven bus |
| pair_err | output | 1 | Sticky flag: a 0xC slot had no matching 0xD |

## Verification
The hardest state to reach from the ports is a request that lands while an earlier word is still partly shifted in. A counter that did not restart would finish its word part-way through the new transfer and store the wrong bits in the wrong bank entry. The bench sends a truncated transfer for one pair and then a full one for a later pair in the same frame. In the next frame it checks both second slots: the new pair must show its own word, and the abandoned pair must show its old value. Random slot maps with biased codes and a small bus range produce many adjacent pairs, orphan heads and mismatched buses. Directed words 0x4000 and 0xBFFF isolate the valid bit from the data byte.

// File: rtl/slot_pair_pkg.sv
package slot_pair_pkg;
  localparam int CODE_W = 4;
  localparam logic [CODE_W-1:0] CODE_HEAD = 4'hC;
  localparam logic [CODE_W-1:0] CODE_TAIL = 4'hD;

  typedef enum logic [1:0] {
    ROLE_NONE   = 2'd0,
    ROLE_HEAD   = 2'd1,
    ROLE_TAIL   = 2'd2,
    ROLE_ORPHAN = 2'd3
  } slot_role_e;
endpackage

// File: rtl/pair_slot_map.sv
module pair_slot_map
  import slot_pair_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int BUS_W     = 2,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              map_we,
  input  logic [SLOT_W-1:0] map_addr,
  input  logic [CODE_W-1:0] map_code,
  input  logic [BUS_W-1:0]  map_bus,
  input  logic [SLOT_W-1:0] look_slot,
  output slot_role_e        role,
  output logic [BUS_W-1:0]  look_bus
);
  logic [CODE_W-1:0] code_mem [NUM_SLOTS];
  logic [BUS_W-1:0]  bus_mem  [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (map_we && (int'(map_addr) < NUM_SLOTS)) begin
      code_mem[map_addr] <= map_code;
      bus_mem[map_addr]  <= map_bus;
    end
  end

  logic              has_next, has_prev;
  logic [SLOT_W-1:0] next_idx, prev_idx;
  logic [CODE_W-1:0] here_code, next_code, prev_code;
  logic [BUS_W-1:0]  next_bus, prev_bus;
  logic              head_here, tail_here;

  always_comb begin
    has_next  = int'(look_slot) < NUM_SLOTS - 1;
    has_prev  = look_slot != '0;
    next_idx  = has_next ? look_slot + SLOT_W'(1) : look_slot;
    prev_idx  = has_prev ? look_slot - SLOT_W'(1) : look_slot;
    here_code = code_mem[look_slot];
    look_bus  = bus_mem[look_slot];
    next_code = code_mem[next_idx];
    next_bus  = bus_mem[next_idx];
    prev_code = code_mem[prev_idx];
    prev_bus  = bus_mem[prev_idx];
    head_here = (here_code == CODE_HEAD) && has_next &&
                (next_code == CODE_TAIL) && (next_bus == look_bus);
    tail_here = (here_code == CODE_TAIL) && has_prev &&
                (prev_code == CODE_HEAD) && (prev_bus == look_bus);
    if (head_here)                    role = ROLE_HEAD;
    else if (here_code == CODE_HEAD)  role = ROLE_ORPHAN;
    else if (tail_here)               role = ROLE_TAIL;
    else                              role = ROLE_NONE;
  end
endmodule

// File: rtl/pair_serial_cap.sv
module pair_serial_cap #(
  parameter int WORD_W    = 16,
  parameter int VALID_BIT = 14,
  parameter int DATA_W    = 8,
  localparam int SH_W     = VALID_BIT,
  localparam int CNT_W    = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              ser_strobe,
  input  logic              ser_bit,
  output logic              done,
  output logic              cap_valid,
  output logic [DATA_W-1:0] cap_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sh;

  // Only the bits that end at or below the valid position are kept.
  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      cnt   <= '0;
      sh    <= '0;
    end else if (start) begin
      armed <= 1'b1;
      cnt   <= '0;
    end else if (armed && ser_strobe) begin
      sh <= {sh[SH_W-2:0], ser_bit};
      if (cnt == LAST) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    done      = armed && ser_strobe && !start && (cnt == LAST);
    cap_valid = sh[SH_W-1];
    cap_data  = {sh[DATA_W-2:0], ser_bit};
  end
endmodule

// File: rtl/pair_bank_store.sv
module pair_bank_store #(
  parameter int NUM_SLOTS = 8,
  parameter int DATA_W    = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_bank,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W:0] bank_mem [2][NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < NUM_SLOTS; s++)
          bank_mem[b][s] <= '0;
    end else if (wr_en && (int'(wr_slot) < NUM_SLOTS)) begin
      bank_mem[wr_bank][wr_slot] <= {wr_valid, wr_data};
    end
  end

  always_comb begin
    {rd_valid, rd_data} = bank_mem[rd_bank][rd_slot];
  end
endmodule

// File: rtl/slot_pair_extractor.sv
module slot_pair_extractor
  import slot_pair_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int BUS_W     = 2,
  parameter int WORD_W    = 16,
  parameter int VALID_BIT = 14,
  parameter int DATA_W    = 8,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_sync,
  input  logic              slot_tick,
  input  logic              map_we,
  input  logic [SLOT_W-1:0] map_addr,
  input  logic [3:0]        map_code,
  input  logic [BUS_W-1:0]  map_bus,
  input  logic              ser_strobe,
  input  logic              ser_bit,
  output logic              dsp_req,
  output logic              out_drive,
  output logic [BUS_W-1:0]  out_bus,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              pair_err
);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

  // Slot sequencing
  logic              synced;
  logic [SLOT_W-1:0] slot_idx;
  logic              frame_par;
  logic              tick_go;
  logic [SLOT_W-1:0] cur_slot;
  logic              new_par;

  always_comb begin
    tick_go = slot_tick && (frame_sync || synced);
    if (frame_sync)               cur_slot = '0;
    else if (slot_idx == LAST_SLOT) cur_slot = slot_idx;
    else                          cur_slot = slot_idx + SLOT_W'(1);
    new_par = frame_par ^ frame_sync;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      synced    <= 1'b0;
      slot_idx  <= '0;
      frame_par <= 1'b0;
    end else if (tick_go) begin
      synced    <= 1'b1;
      slot_idx  <= cur_slot;
      frame_par <= new_par;
    end
  end

  // Code decoding
  slot_role_e       role;
  logic [BUS_W-1:0] look_bus;

  pair_slot_map #(.NUM_SLOTS(NUM_SLOTS), .BUS_W(BUS_W)) u_map (
    .clk      (clk),
    .map_we   (map_we),
    .map_addr (map_addr),
    .map_code (map_code),
    .map_bus  (map_bus),
    .look_slot(cur_slot),
    .role     (role),
    .look_bus (look_bus)
  );

  // Serial capture and write-target latch
  logic              start_cap;
  logic              cap_done, cap_valid;
  logic [DATA_W-1:0] cap_data;
  logic [SLOT_W-1:0] tgt_slot;
  logic              tgt_bank;

  assign start_cap = tick_go && (role == ROLE_HEAD);

  pair_serial_cap #(.WORD_W(WORD_W), .VALID_BIT(VALID_BIT), .DATA_W(DATA_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .start     (start_cap),
    .ser_strobe(ser_strobe),
    .ser_bit   (ser_bit),
    .done      (cap_done),
    .cap_valid (cap_valid),
    .cap_data  (cap_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_slot <= '0;
      tgt_bank <= 1'b0;
    end else if (start_cap) begin
      tgt_slot <= cur_slot + SLOT_W'(1);
      tgt_bank <= new_par;
    end
  end

  // Two-bank store: capture into this frame's bank, read last frame's
  logic              st_valid;
  logic [DATA_W-1:0] st_data;

  pair_bank_store #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cap_done),
    .wr_bank (tgt_bank),
    .wr_slot (tgt_slot),
    .wr_valid(cap_valid),
    .wr_data (cap_data),
    .rd_bank (~new_par),
    .rd_slot (cur_slot),
    .rd_valid(st_valid),
    .rd_data (st_data)
  );

  // Output register
  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_req   <= 1'b0;
      out_drive <= 1'b0;
      out_bus   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      pair_err  <= 1'b0;
    end else begin
      dsp_req <= start_cap;
      if (tick_go) begin
        unique case (role)
          ROLE_HEAD, ROLE_ORPHAN: begin
            out_drive <= 1'b1;
            out_bus   <= look_bus;
            out_valid <= 1'b0;
            out_data  <= '0;
          end
          ROLE_TAIL: begin
            out_drive <= 1'b1;
            out_bus   <= look_bus;
            out_valid <= st_valid;
            out_data  <= st_data;
          end
          default: begin
            out_drive <= 1'b0;
            out_bus   <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
          end
        endcase
        if (role == ROLE_ORPHAN) pair_err <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slot_pair_extractor_chk.sv
module slot_pair_extractor_chk #(
  parameter int BUS_W  = 2,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              slot_tick,
  input logic              dsp_req,
  input logic              out_drive,
  input logic [BUS_W-1:0]  out_bus,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              pair_err
);
  // R1
  req_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_req |=> !dsp_req);

  // R1
  req_after_tick_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_req |-> $past(slot_tick));

  // R2
  head_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dsp_req |-> (out_drive && !out_valid));

  // R5
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    pair_err |=> pair_err);

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !out_drive |-> (!out_valid && out_data == '0 && out_bus == '0));
endmodule

bind slot_pair_extractor slot_pair_extractor_chk #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .slot_tick(slot_tick),
  .dsp_req  (dsp_req),
  .out_drive(out_drive),
  .out_bus  (out_bus),
  .out_valid(out_valid),
  .out_data (out_data),
  .pair_err (pair_err)
);

// File: tb/slot_pair_extractor_bench.sv
module slot_pair_extractor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int BW = 2;
  localparam int SW = 3;
  localparam int SLOT_CYC = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0, slot_tick = 1'b0;
  logic map_we = 1'b0;
  logic [SW-1:0] map_addr = '0;
  logic [3:0] map_code = '0;
  logic [BW-1:0] map_bus = '0;
  logic ser_strobe = 1'b0, ser_bit = 1'b0;
  logic dsp_req, out_drive, out_valid, pair_err;
  logic [BW-1:0] out_bus;
  logic [7:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_pair_extractor u_slot_pair_extractor (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .slot_tick(slot_tick),
    .map_we(map_we), .map_addr(map_addr), .map_code(map_code), .map_bus(map_bus),
    .ser_strobe(ser_strobe), .ser_bit(ser_bit), .dsp_req(dsp_req),
    .out_drive(out_drive), .out_bus(out_bus), .out_valid(out_valid),
    .out_data(out_data), .pair_err(pair_err)
  );

  int total = 0, bad = 0;
  int mc [NS];
  int mb [NS];
  logic ev [2][NS];
  logic [7:0] ed [2][NS];
  int mpar = 0;
  logic merr = 1'b0;
  string tail_tag = "R4";
  int partial_slot = -1;
  logic use_fixed = 1'b0;
  logic [15:0] fixed_w [NS];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit m_head(int n);
    return mc[n] == 12 && n < NS-1 && mc[n+1] == 13 && mb[n+1] == mb[n];
  endfunction
  function automatic bit m_tail(int n);
    return n > 0 && m_head(n-1);
  endfunction
  function automatic bit m_orphan(int n);
    return mc[n] == 12 && !m_head(n);
  endfunction

  task automatic put_map(int n, int code, int bus);
    @(negedge clk);
    map_we = 1'b1; map_addr = SW'(n); map_code = 4'(code); map_bus = BW'(bus);
    mc[n] = code; mb[n] = bus;
    @(negedge clk);
    map_we = 1'b0;
  endtask

  task automatic run_slot(int n);
    int used;
    int nb;
    logic [15:0] w;
    @(negedge clk);
    frame_sync = (n == 0); slot_tick = 1'b1;
    if (n == 0) mpar ^= 1;
    @(negedge clk);
    slot_tick = 1'b0; frame_sync = 1'b0;
    used = 1;
    merr = merr | m_orphan(n);
    chk("R1 req", dsp_req, m_head(n));
    chk("R5 err", pair_err, merr);
    if (m_head(n)) begin
      chk("R2 drive", out_drive, 1); chk("R2 bus", out_bus, mb[n]); chk("R2 valid", out_valid, 0);
    end else if (m_orphan(n)) begin
      chk("R5 drive", out_drive, 1); chk("R5 valid", out_valid, 0);
    end else if (m_tail(n)) begin
      chk({tail_tag, " drive"}, out_drive, 1);
      chk({tail_tag, " bus"}, out_bus, mb[n]);
      chk({tail_tag, " R3 valid"}, out_valid, ev[mpar^1][n]);
      chk({tail_tag, " R3 data"}, out_data, ed[mpar^1][n]);
    end else begin
      chk("R6 drive", out_drive, 0); chk("R6 valid", out_valid, 0); chk("R6 data", out_data, 0);
    end
    if (m_head(n)) begin
      w = use_fixed ? fixed_w[n] : 16'($urandom);
      nb = (n == partial_slot) ? 5 : 16;
      for (int b = 0; b < nb; b++) begin
        ser_strobe = 1'b1; ser_bit = w[15-b];
        @(negedge clk);
        used++;
      end
      ser_strobe = 1'b0;
      if (nb == 16) begin
        ev[mpar][n+1] = w[14];
        ed[mpar][n+1] = w[7:0];
      end
    end
    while (used < SLOT_CYC) begin
      @(negedge clk);
      used++;
    end
  endtask

  task automatic run_frame();
    for (int n = 0; n < NS; n++) run_slot(n);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'h5107));
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < NS; s++) begin ev[b][s] = 1'b0; ed[b][s] = 8'h00; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R7 reset state
    chk("R7 req", dsp_req, 0); chk("R7 drive", out_drive, 0);
    chk("R7 valid", out_valid, 0); chk("R7 data", out_data, 0);
    chk("R7 bus", out_bus, 0); chk("R7 err", pair_err, 0);

    // Map with three pairs, an idle code and an orphan tail, no orphan head
    put_map(0, 12, 1); put_map(1, 13, 1); put_map(2, 3, 2); put_map(3, 12, 2);
    put_map(4, 13, 2); put_map(5, 12, 3); put_map(6, 13, 3); put_map(7, 13, 0);

    // R9: ticks before the first frame_sync are ignored
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); slot_tick = 1'b1;
      @(negedge clk); slot_tick = 1'b0;
      chk("R9 drive", out_drive, 0);
      chk("R9 req", dsp_req, 0);
    end

    // R7: first frame reads never-written bank
    tail_tag = "R7";
    run_frame();
    tail_tag = "R4";
    // Directed words isolating valid bit from data
    use_fixed = 1'b1;
    fixed_w[0] = 16'h4000; fixed_w[3] = 16'hBFFF; fixed_w[5] = 16'h7F5A;
    run_frame();
    use_fixed = 1'b0;
    run_frame();
    run_frame();

    // R8: truncated transfer on pair at slot 0, full on slot 3
    partial_slot = 0;
    run_frame();
    partial_slot = -1;
    tail_tag = "R8";
    run_frame();
    tail_tag = "R4";
    run_frame();

    // R5: orphan head at the last slot and a bus mismatch
    put_map(7, 12, 0);
    put_map(4, 13, 1);
    run_frame();
    run_frame();

    // Random maps
    for (int f = 0; f < 24; f++) begin
      if (f % 3 == 0) begin
        for (int n = 0; n < NS; n++) begin
          int r;
          r = int'($urandom % 5);
          put_map(n, (r < 2) ? 12 : (r < 4) ? 13 : ((r == 4) ? 3 : 14), int'($urandom % 2));
        end
      end
      run_frame();
    end
    finish_up();
  end
endmodule